// File: doc/BRIEF.md
# Key-Guarded Oscillator Switch Controller

This block holds a 16-bit oscillator control word behind a byte-write bus that carries at most one write per cycle. Neither byte of the word can be changed by an ordinary store. Each byte lane has its own small key checker. Two fixed key bytes, written to that lane back to back, open the lane for exactly one further write. Any other write to that lane closes it again. The high lane carries the requested oscillator code. The low lane carries the switch-enable flag.

Once switch-enable is set, the controller waits for the clock switch to become possible. The target source must report ready. If the target is a PLL-derived code, the synchronized PLL lock input must also be high. When both hold, the controller makes the requested code current and clears switch-enable. Software polls switch-enable to see whether the switch has finished. When the current source is PLL-derived, a lock status bit shows why a switch may be stalled. The bus, the ready input and the lock input are plain level or strobe signals, with no valid/ready handshake: the bus never stalls, and each write takes effect at the clock edge on which it is presented.

Top module: `osc_switch_guard`

## Requirements
- R1: After reset, the current-oscillator field and the requested-oscillator field both hold the RESET_OSC parameter (default 0), switch-enable is 0, lock status is 0, and both key checkers are closed.
- R2: The high lane opens after writes of 78h and then 9Ah to bus_wdata[15:8], made as consecutive high-lane writes (bus_be[1]=1). The next high-lane write loads the requested-oscillator field from bus_wdata[10:8].
- R3: The low lane opens after writes of 46h and then 57h to bus_wdata[7:0], made as consecutive low-lane writes (bus_be[0]=1). The next low-lane write loads switch-enable from bus_wdata[0].
- R4: A write to a lane that has not been opened leaves that lane's fields unchanged.
- R5: An opened lane accepts only the single write that follows its second key. The write after that is ignored.
- R6: A lane write that does not continue the key sequence returns that lane to closed, and a later second key alone does not open it. Cycles without a write to the lane leave the sequence in progress intact.
- R7: While switch-enable is 1 and the requested code differs from the current code, nothing changes until src_ready is 1. For PLL codes (PLL_MASK bit set; by default codes 1 and 3), the synchronized lock must also be 1. On the edge where both hold, the current field takes the requested code and switch-enable clears.
- R8: If switch-enable is set while the requested code equals the current code, switch-enable clears on the next clock edge and the current field is unchanged, whatever src_ready is.
- R9: lock_status equals pll_lock_in delayed through a two-stage synchronizer when the current code is a PLL code, and is 0 otherwise.
- R10: reg_rdata shows the current code in bits 14:12, the requested code in bits 10:8, lock status in bit 5 and switch-enable in bit 0, with all other bits 0. Bits 14:12 cannot be written from the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_be | input | 2 | Byte lane enables: bit 1 high byte, bit 0 low byte |
| bus_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current view of the control word |
| src_ready | input | 1 | Target oscillator reports it is running |
| pll_lock_in | input | 1 | Asynchronous PLL lock indication |
| lock_status | output | 1 | Synchronized lock, gated by PLL current source |
| cur_osc | output | 3 | Active oscillator code |

## Verification
The bench attacks the key checkers with a broken sequence (first key, a wrong byte, then the second key), with idle cycles placed between the keys, and with a second write inside an open window. A checker that stayed armed on a mismatch, or that kept its window open, would let the stray write change the requested code. The switch is held back by a low src_ready and then by a low PLL lock, and the bench counts the edges from the lock rising to switch-enable clearing. A design that skipped the synchronizer, or that ignored lock for PLL codes, would finish early. A same-code request is made with src_ready low: a design that waited for the handshake would leave switch-enable stuck. A write to the read-only field through an open high window must also leave the current code unchanged.

// File: rtl/osc_guard_pkg.sv
package osc_guard_pkg;
  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_ARMED  = 2'd1,
    LK_OPEN   = 2'd2
  } lane_state_e;

  localparam int WORD_W   = 16;
  localparam int LANES    = 2;
  localparam int CUR_LSB  = 12;
  localparam int NEW_LSB  = 8;
  localparam int LOCK_BIT = 5;
  localparam int SWEN_BIT = 0;
endpackage

// File: rtl/osc_guard_lane.sv
module osc_guard_lane
  import osc_guard_pkg::*;
#(
  parameter logic [7:0] KEY_FIRST  = 8'h00,
  parameter logic [7:0] KEY_SECOND = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_byte,
  output logic       accept
);
  lane_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_stb) begin
      unique case (state_q)
        LK_CLOSED: state_d = (wr_byte == KEY_FIRST)  ? LK_ARMED : LK_CLOSED;
        LK_ARMED:  state_d = (wr_byte == KEY_SECOND) ? LK_OPEN  : LK_CLOSED;
        LK_OPEN:   state_d = LK_CLOSED;
        default:   state_d = LK_CLOSED;
      endcase
    end
  end

  // the single write that lands in the open state is the one let through
  assign accept = wr_stb && (state_q == LK_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_CLOSED;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/osc_guard_sync.sv
module osc_guard_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/osc_guard_seq.sv
module osc_guard_seq #(
  parameter int               OSC_W     = 3,
  parameter logic [OSC_W-1:0] RESET_OSC = '0,
  parameter logic [(1<<OSC_W)-1:0] PLL_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [OSC_W-1:0] sel_val,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic             src_ready,
  input  logic             lock_sync,
  output logic [OSC_W-1:0] new_osc,
  output logic [OSC_W-1:0] cur_osc,
  output logic             swen
);
  logic target_pll, same_sel, can_switch;

  assign target_pll = PLL_MASK[new_osc];
  assign same_sel   = (new_osc == cur_osc);
  assign can_switch = src_ready && (!target_pll || lock_sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_osc <= RESET_OSC;
      new_osc <= RESET_OSC;
      swen    <= 1'b0;
    end else begin
      if (sel_wr) new_osc <= sel_val;
      if (swen) begin
        if (same_sel) begin
          swen <= 1'b0;
        end else if (can_switch) begin
          cur_osc <= new_osc;
          swen    <= 1'b0;
        end
      end
      // an accepted low-lane write takes priority over completion
      if (en_wr) swen <= en_val;
    end
  end
endmodule

// File: rtl/osc_switch_guard.sv
module osc_switch_guard
  import osc_guard_pkg::*;
#(
  parameter int               OSC_W     = 3,
  parameter logic [OSC_W-1:0] RESET_OSC = '0,
  parameter logic [(1<<OSC_W)-1:0] PLL_MASK = 8'b0000_1010,
  parameter int               SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] reg_rdata,
  input  logic        src_ready,
  input  logic        pll_lock_in,
  output logic        lock_status,
  output logic [2:0]  cur_osc
);
  localparam logic [7:0] HI_K1 = 8'h78;
  localparam logic [7:0] HI_K2 = 8'h9A;
  localparam logic [7:0] LO_K1 = 8'h46;
  localparam logic [7:0] LO_K2 = 8'h57;

  logic [LANES-1:0] lane_accept;
  logic             lock_sync;
  logic [OSC_W-1:0] new_osc_q, cur_osc_q;
  logic             swen_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    osc_guard_lane #(
      .KEY_FIRST (g == 1 ? HI_K1 : LO_K1),
      .KEY_SECOND(g == 1 ? HI_K2 : LO_K2)
    ) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (bus_we && bus_be[g]),
      .wr_byte(bus_wdata[g*8 +: 8]),
      .accept (lane_accept[g])
    );
  end

  osc_guard_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(pll_lock_in),
    .q_sync (lock_sync)
  );

  osc_guard_seq #(
    .OSC_W    (OSC_W),
    .RESET_OSC(RESET_OSC),
    .PLL_MASK (PLL_MASK)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_wr   (lane_accept[1]),
    .sel_val  (bus_wdata[NEW_LSB +: OSC_W]),
    .en_wr    (lane_accept[0]),
    .en_val   (bus_wdata[SWEN_BIT]),
    .src_ready(src_ready),
    .lock_sync(lock_sync),
    .new_osc  (new_osc_q),
    .cur_osc  (cur_osc_q),
    .swen     (swen_q)
  );

  assign lock_status = PLL_MASK[cur_osc_q] & lock_sync;
  assign cur_osc     = cur_osc_q;

  always_comb begin
    reg_rdata                       = '0;
    reg_rdata[CUR_LSB +: OSC_W]     = cur_osc_q;
    reg_rdata[NEW_LSB +: OSC_W]     = new_osc_q;
    reg_rdata[LOCK_BIT]             = lock_status;
    reg_rdata[SWEN_BIT]             = swen_q;
  end
endmodule

// File: rtl/osc_switch_guard_chk.sv
module osc_switch_guard_chk #(
  parameter int OSC_W = 3,
  parameter logic [(1<<OSC_W)-1:0] PLL_MASK = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [1:0]       bus_be,
  input logic             src_ready,
  input logic             lock_status,
  input logic [OSC_W-1:0] cur_osc,
  input logic [OSC_W-1:0] new_osc,
  input logic             swen
);
  // R7: the active code moves only while a switch was requested
  p_cur_needs_swen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_osc != $past(cur_osc)) |-> $past(swen));

  // R7: the active code moves only after the source reported ready
  p_cur_needs_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_osc != $past(cur_osc)) |-> $past(src_ready));

  // R4 / R5: the requested code moves only on a high-lane write
  p_new_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (new_osc != $past(new_osc)) |-> $past(bus_we && bus_be[1]));

  // R3: switch-enable is raised only by a low-lane write
  p_swen_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swen) |-> $past(bus_we && bus_be[0]));

  // R8: a same-code request is dropped on the next edge
  p_same_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (swen && new_osc == cur_osc && !(bus_we && bus_be[0])) |=> !swen);

  // R9: no lock report for a non-PLL active source
  p_lock_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !PLL_MASK[cur_osc] |-> !lock_status);
endmodule

bind osc_switch_guard osc_switch_guard_chk #(
  .OSC_W   (OSC_W),
  .PLL_MASK(PLL_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_be     (bus_be),
  .src_ready  (src_ready),
  .lock_status(lock_status),
  .cur_osc    (cur_osc_q),
  .new_osc    (new_osc_q),
  .swen       (swen_q)
);

// File: tb/osc_switch_guard_bench.sv
module osc_switch_guard_bench;
  localparam time PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata;
  logic [15:0] reg_rdata;
  logic        src_ready;
  logic        pll_lock_in;
  logic        lock_status;
  logic [2:0]  cur_osc;

  int n_checks = 0;
  int n_fail   = 0;

  always #(PERIOD/2) clk = ~clk;

  osc_switch_guard u_osc_switch_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .reg_rdata  (reg_rdata),
    .src_ready  (src_ready),
    .pll_lock_in(pll_lock_in),
    .lock_status(lock_status),
    .cur_osc    (cur_osc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    bus_we = 1'b1; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_be = 2'b00; bus_wdata = 16'h0000;
  endtask

  task automatic open_hi(input logic [2:0] code);
    wr(2'b10, 16'h7800);
    wr(2'b10, 16'h9A00);
    wr(2'b10, {5'b0, code, 8'h00});
  endtask

  task automatic open_lo(input logic bit0);
    wr(2'b01, 16'h0046);
    wr(2'b01, 16'h0057);
    wr(2'b01, {15'b0, bit0});
  endtask

  task automatic t_reset;
    pll_lock_in = 1'b1;
    step(3);
    check("R1 word", reg_rdata, 16'h0000);
    check("R1 cur", cur_osc, 3'd0);
    check("R9 lock gated non-PLL", lock_status, 1'b0);
  endtask

  task automatic t_no_unlock;
    wr(2'b10, 16'h0500);
    check("R4 hi ignored", reg_rdata[10:8], 3'd0);
    wr(2'b01, 16'h0001);
    check("R4 lo ignored", reg_rdata[0], 1'b0);
  endtask

  task automatic t_hi_unlock;
    wr(2'b10, 16'h7800);
    wr(2'b10, 16'h9A00);
    wr(2'b10, 16'h7200);
    check("R2 new loaded", reg_rdata[10:8], 3'd2);
    check("R10 cur read-only", reg_rdata[14:12], 3'd0);
    wr(2'b10, 16'h0400);
    check("R5 second write ignored", reg_rdata[10:8], 3'd2);
  endtask

  task automatic t_broken;
    wr(2'b10, 16'h7800);
    wr(2'b10, 16'h5500);
    wr(2'b10, 16'h9A00);
    wr(2'b10, 16'h0500);
    check("R6 broken seq", reg_rdata[10:8], 3'd2);
    wr(2'b10, 16'h7800);
    step(3);
    wr(2'b10, 16'h9A00);
    step(2);
    wr(2'b10, 16'h0600);
    check("R6 idle gaps kept", reg_rdata[10:8], 3'd6);
  endtask

  task automatic t_switch_ready;
    src_ready = 1'b0;
    open_lo(1'b1);
    check("R3 swen set", reg_rdata[0], 1'b1);
    step(3);
    check("R7 waits ready swen", reg_rdata[0], 1'b1);
    check("R7 waits ready cur", cur_osc, 3'd0);
    src_ready = 1'b1;
    step(1);
    check("R7 done swen", reg_rdata[0], 1'b0);
    check("R7 done cur", cur_osc, 3'd6);
    check("R10 cur field", reg_rdata[14:12], 3'd6);
  endtask

  task automatic t_switch_pll;
    pll_lock_in = 1'b0;
    step(3);
    open_hi(3'd3);
    open_lo(1'b1);
    step(4);
    check("R7 waits lock swen", reg_rdata[0], 1'b1);
    check("R7 waits lock cur", cur_osc, 3'd6);
    check("R9 non-PLL cur", lock_status, 1'b0);
    pll_lock_in = 1'b1;
    step(1);
    check("R7 sync delay", reg_rdata[0], 1'b1);
    step(2);
    check("R7 pll done swen", reg_rdata[0], 1'b0);
    check("R7 pll done cur", cur_osc, 3'd3);
    check("R9 lock shown", lock_status, 1'b1);
    check("R10 lock bit", reg_rdata[5], 1'b1);
    pll_lock_in = 1'b0;
    step(1);
    check("R9 lock delayed", lock_status, 1'b1);
    step(1);
    check("R9 lock drops", lock_status, 1'b0);
    pll_lock_in = 1'b1;
    step(2);
  endtask

  task automatic t_same_sel;
    src_ready = 1'b0;
    open_lo(1'b1);
    check("R8 swen seen", reg_rdata[0], 1'b1);
    step(1);
    check("R8 swen cleared", reg_rdata[0], 1'b0);
    check("R8 cur kept", cur_osc, 3'd3);
    check("R10 word", reg_rdata, 16'h3320);
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_be = 2'b00; bus_wdata = 16'h0000;
    src_ready = 1'b0; pll_lock_in = 1'b0;
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_no_unlock();
    t_hi_unlock();
    t_broken();
    t_switch_ready();
    t_switch_pll();
    t_same_sel();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(PERIOD * 50000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule